// File: doc/BRIEF.md
# Channel-Paged Register Bank with Broadcast Write

This block is a byte-wide register file that sits behind a simple host register port. The port has an address, write data, a write strobe, a read strobe and registered read data. One 8-bit address space is shared by a common control register set and four per-channel register sets. A page-select register at address 0xFF decides where an access goes. It can point at the common set, at one chosen channel, or at all four channels at once for writes. The page-select register can always be reached, whatever page is active.

The common set holds several things: a strapped bus-address view, a fixed identity byte, a self-clearing soft reset for the common registers, a self-clearing master-reset pulse and an interrupt status view. In the status view, the per-channel interrupt flags appear in reverse channel order. Each channel set has `CH_REGS` plain read/write bytes starting at address 0x00. The serial bus engine, the configuration loader and the channel datapath stay outside the block. Only strobes and status inputs stand for them.

Top module: `chan_page_regbank`

## Requirements
- R1: A write to 0xFF always updates the page-select byte, whatever the current page, and no channel register changes. A read of 0xFF always returns the page-select byte.
- R2: While page-select bit 2 is 0, reads and writes to addresses other than 0xFF reach only the common set, and no channel register changes.
- R3: While page-select bit 2 is 1 and bit 3 is 0, reads and writes reach only the channel whose index is page-select bits 1:0.
- R4: While page-select bits 3 and 2 are both 1, a write to any address other than 0xFF updates that address in all four channels in the same cycle. Reads return data from the channel given by bits 1:0.
- R5: Writes to read-only locations change nothing. These locations are common 0x00, common 0x01 and common 0x05 bits 4:0.
- R6: Writing 1 to common 0x04 bit 6 returns every common register, including page-select, to its reset value on that clock edge. The bit reads back 0, and the channel registers keep their contents.
- R7: Writing 1 to common 0x04 bit 5 drives `master_rst_pulse` high for exactly the one cycle after the write. The bit reads back 0.
- R8: Common 0x00 reads {strap_addr, 4'b0000}, and `bus_addr` equals 0x18 + `strap_addr`. Common 0x01 reads 0xD1.
- R9: Common 0x05 reads as follows. Bit 3 is channel 0's interrupt, bit 2 is channel 1's, bit 1 is channel 2's and bit 0 is channel 3's. Bit 4 is `load_done`. Bits 7:5 are read/write.
- R10: After reset, page-select reads 0x00, 0x04 reads 0x01, 0x07 reads 0x05, and the other common read/write bits read 0. Channel registers reset to 0x00.
- R11: Channel addresses at or above `CH_REGS`, and common addresses other than 0x00–0x07 and 0xFF, read 0x00 and discard writes.
- R12: `rdata` updates on the clock edge that samples `rd_en` and otherwise holds its value. A read that coincides with a write to the same location returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data, valid one cycle after `rd_en` |
| strap_addr | input | 4 | Strapped low bits of the device bus address |
| load_done | input | 1 | Configuration-load-complete status |
| ch_irq | input | 4 | Per-channel interrupt flags, bit i = channel i |
| bus_addr | output | 7 | Device bus address, 0x18 + `strap_addr` |
| master_rst_pulse | output | 1 | One-cycle master-mode reset request |

## Verification
The hardest state to reach from the ports is a mixed history across pages. In that state, distinct values sit in each channel, a broadcast has overwritten one address in all four, and a common soft reset has cleared page-select without touching those values. The stimulus gets there in steps. It first gives each channel its own value through single-channel pages. It then switches to broadcast and reads back through several channel selections. Finally it triggers the soft reset from a page-select that holds nonzero reserved bits, and re-opens a channel page to confirm that the channel data survived.

// File: rtl/crb_pkg.sv
// Package: shared constants for the channel-paged register bank.
// Assumes a byte-wide port and a two-bit channel index (four channels).
package crb_pkg;
    localparam int CH_SEL_W = 2;
    localparam int NUM_CH   = 1 << CH_SEL_W;

    localparam logic [7:0] A_STRAP = 8'h00;
    localparam logic [7:0] A_IDENT = 8'h01;
    localparam logic [7:0] A_SCR2  = 8'h02;
    localparam logic [7:0] A_SCR3  = 8'h03;
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_STAT  = 8'h05;
    localparam logic [7:0] A_SCR6  = 8'h06;
    localparam logic [7:0] A_SCR7  = 8'h07;
    localparam logic [7:0] A_PAGE  = 8'hFF;

    localparam logic [7:0] IDENT_VAL  = 8'hD1;
    localparam logic [7:0] CTRL_RST   = 8'h01;
    localparam logic [7:0] SCR7_RST   = 8'h05;
    localparam logic [6:0] BUS_BASE   = 7'h18;

    // Bit positions in the control byte and the page-select byte
    localparam int CTRL_SOFTRST_B = 6;
    localparam int CTRL_MRST_B    = 5;
    localparam int PAGE_CHEN_B    = 2;
    localparam int PAGE_ALL_B     = 3;
endpackage

// File: rtl/crb_chan_regs.sv
// Module: one channel's register set.
// Holds CH_REGS bytes at addresses 0..CH_REGS-1. The caller qualifies
// the write enable with paging and range. Reads are combinational from
// raddr, which the caller keeps in range.
module crb_chan_regs #(
    parameter int CH_REGS = 8,
    localparam int CH_AW  = $clog2(CH_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [CH_AW-1:0]       waddr,
    input  logic [7:0]             wdata,
    input  logic [CH_AW-1:0]       raddr,
    output logic [7:0]             rdata,
    output logic [CH_REGS*8-1:0]   regs_flat
);
    logic [7:0] mem [CH_REGS];

    // Store a byte on a qualified write; clear all bytes on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH_REGS; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the addressed byte
    always_comb rdata = mem[raddr];

    // Flatten the bytes for observation by the checker
    always_comb begin
        for (int i = 0; i < CH_REGS; i++) regs_flat[i*8 +: 8] = mem[i];
    end
endmodule

// File: rtl/crb_shared_regs.sv
// Module: common (shared) register set plus the page-select byte.
// Assumes the caller asserts `we` only for writes that target this set
// (any 0xFF write, or any write while channel paging is off). A write
// with control bit 6 set restores every register here to its default.
module crb_shared_regs
    import crb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic [3:0] strap_addr,
    input  logic       load_done,
    input  logic [3:0] ch_irq,
    output logic [7:0] page_sel,
    output logic [7:0] rd_val,
    output logic       mrst_pulse
);
    logic [7:0] scr2_q, scr3_q, ctrl_q, scr6_q, scr7_q;
    logic [2:0] stat_hi_q;
    logic       soft_rst;
    logic [3:0] irq_rev;

    // Detect the self-clearing soft reset request
    always_comb soft_rst = we && (addr == A_CTRL) && wdata[CTRL_SOFTRST_B];

    // Update the writable common bytes, honouring defaults and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            page_sel  <= 8'h00;
            scr2_q    <= 8'h00;
            scr3_q    <= 8'h00;
            ctrl_q    <= CTRL_RST;
            scr6_q    <= 8'h00;
            scr7_q    <= SCR7_RST;
            stat_hi_q <= 3'b000;
        end else if (we) begin
            case (addr)
                A_PAGE: page_sel  <= wdata;
                A_SCR2: scr2_q    <= wdata;
                A_SCR3: scr3_q    <= wdata;
                A_CTRL: ctrl_q    <= {wdata[7], 2'b00, wdata[4:0]};
                A_STAT: stat_hi_q <= wdata[7:5];
                A_SCR6: scr6_q    <= wdata;
                A_SCR7: scr7_q    <= wdata;
                default: ;
            endcase
        end
    end

    // One-cycle master reset request, never stored in the control byte
    always_ff @(posedge clk) begin
        if (!rst_n) mrst_pulse <= 1'b0;
        else        mrst_pulse <= we && (addr == A_CTRL) && wdata[CTRL_MRST_B];
    end

    // Interrupt flags shown in reverse channel order
    always_comb begin
        for (int i = 0; i < 4; i++) irq_rev[3-i] = ch_irq[i];
    end

    // Read value of the common location at addr
    always_comb begin
        case (addr)
            A_STRAP: rd_val = {strap_addr, 4'b0000};
            A_IDENT: rd_val = IDENT_VAL;
            A_SCR2:  rd_val = scr2_q;
            A_SCR3:  rd_val = scr3_q;
            A_CTRL:  rd_val = ctrl_q;
            A_STAT:  rd_val = {stat_hi_q, load_done, irq_rev};
            A_SCR6:  rd_val = scr6_q;
            A_SCR7:  rd_val = scr7_q;
            A_PAGE:  rd_val = page_sel;
            default: rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/chan_page_regbank.sv
// Module: top of the channel-paged register bank.
// Decodes each access to the common set, one channel, or all channels
// (broadcast write) from the page-select byte, and registers read data.
// Assumes at most one access per cycle besides a coincident read/write.
module chan_page_regbank
    import crb_pkg::*;
#(
    parameter int CH_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rdata,
    input  logic [3:0] strap_addr,
    input  logic       load_done,
    input  logic [3:0] ch_irq,
    output logic [6:0] bus_addr,
    output logic       master_rst_pulse
);
    localparam int         CH_AW  = $clog2(CH_REGS);
    localparam logic [8:0] CH_LIM = 9'(CH_REGS);
    localparam int         FLAT_W = NUM_CH * CH_REGS * 8;

    logic [7:0]          page_sel;
    logic [7:0]          shared_rd;
    logic                page_hit, shared_acc, shared_wr, ch_in_range;
    logic [CH_SEL_W-1:0] ch_idx;
    logic [NUM_CH-1:0]   ch_we;
    logic [7:0]          ch_rd [NUM_CH];
    logic [FLAT_W-1:0]   ch_flat;
    logic [CH_AW-1:0]    ch_addr;
    logic [7:0]          rd_next;

    // Classify the access against the current page
    always_comb begin
        page_hit    = (addr == A_PAGE);
        shared_acc  = page_hit || !page_sel[PAGE_CHEN_B];
        shared_wr   = wr_en && shared_acc;
        ch_in_range = ({1'b0, addr} < CH_LIM);
        ch_idx      = page_sel[CH_SEL_W-1:0];
        ch_addr     = ch_in_range ? addr[CH_AW-1:0] : '0;
    end

    crb_shared_regs u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (shared_wr),
        .addr       (addr),
        .wdata      (wdata),
        .strap_addr (strap_addr),
        .load_done  (load_done),
        .ch_irq     (ch_irq),
        .page_sel   (page_sel),
        .rd_val     (shared_rd),
        .mrst_pulse (master_rst_pulse)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel write enable: single selection or broadcast
        always_comb ch_we[c] = wr_en && !shared_acc && ch_in_range &&
                               (page_sel[PAGE_ALL_B] || (ch_idx == CH_SEL_W'(c)));

        crb_chan_regs #(.CH_REGS(CH_REGS)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (ch_we[c]),
            .waddr     (ch_addr),
            .wdata     (wdata),
            .raddr     (ch_addr),
            .rdata     (ch_rd[c]),
            .regs_flat (ch_flat[c*CH_REGS*8 +: CH_REGS*8])
        );
    end

    // Choose the read source from the page and the address range
    always_comb begin
        if (shared_acc)       rd_next = shared_rd;
        else if (ch_in_range) rd_next = ch_rd[ch_idx];
        else                  rd_next = 8'h00;
    end

    // Capture read data on a read strobe, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_next;
    end

    // Device bus address from the strap
    always_comb bus_addr = BUS_BASE + {3'b000, strap_addr};
endmodule

// File: rtl/crb_checker.sv
// Module: assertion checker for chan_page_regbank, attached by bind.
// Observes the port, the page-select byte, the common write qualifier
// and the flattened channel contents.
module crb_checker #(
    parameter int FLAT_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        addr,
    input logic [7:0]        wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic [7:0]        page_sel,
    input logic              shared_wr,
    input logic              master_rst_pulse,
    input logic [FLAT_W-1:0] ch_flat
);
    // R1
    page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'hFF) |=> (page_sel == $past(wdata)));

    // R1
    page_write_no_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'hFF) |=> $stable(ch_flat));

    // R2
    shared_page_ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_sel[2]) |=> $stable(ch_flat));

    // R6
    soft_reset_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_wr && addr == 8'h04 && wdata[6]) |=> (page_sel == 8'h00));

    // R7
    mrst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_rst_pulse) |-> $past(shared_wr && addr == 8'h04 && wdata[5]));

    // R8
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 8'h01 && !page_sel[2]) |=> (rdata == 8'hD1));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata));
endmodule

bind chan_page_regbank crb_checker #(.FLAT_W(FLAT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .addr             (addr),
    .wdata            (wdata),
    .wr_en            (wr_en),
    .rd_en            (rd_en),
    .rdata            (rdata),
    .page_sel         (page_sel),
    .shared_wr        (shared_wr),
    .master_rst_pulse (master_rst_pulse),
    .ch_flat          (ch_flat)
);

// File: tb/tb_chan_page_regbank.sv
// Bench: vector table walk followed by directed corner-case tests.
module tb_chan_page_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic [3:0] strap_addr = 4'hA;
    logic       load_done = 1'b1;
    logic [3:0] ch_irq = 4'b0011;
    logic [6:0] bus_addr;
    logic       master_rst_pulse;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chan_page_regbank #(.CH_REGS(8)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .strap_addr(strap_addr), .load_done(load_done), .ch_irq(ch_irq),
        .bus_addr(bus_addr), .master_rst_pulse(master_rst_pulse)
    );

    // Vector: {is_read, req, addr, wdata, expected}
    localparam int NV = 40;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 4'd8,  8'h00, 8'h00, 8'hA0},  // R8 strap view
        {1'b1, 4'd8,  8'h01, 8'h00, 8'hD1},  // R8 identity
        {1'b0, 4'd5,  8'h00, 8'h55, 8'h00},
        {1'b1, 4'd5,  8'h00, 8'h00, 8'hA0},  // R5 read-only strap
        {1'b0, 4'd5,  8'h01, 8'h00, 8'h00},
        {1'b1, 4'd5,  8'h01, 8'h00, 8'hD1},  // R5 read-only identity
        {1'b0, 4'd2,  8'h02, 8'h3C, 8'h00},
        {1'b1, 4'd2,  8'h02, 8'h00, 8'h3C},  // R2 common scratch
        {1'b1, 4'd9,  8'h05, 8'h00, 8'h1C},  // R9 reversed irq + done
        {1'b0, 4'd9,  8'h05, 8'hFF, 8'h00},
        {1'b1, 4'd9,  8'h05, 8'h00, 8'hFC},  // R9 / R5 low bits protected
        {1'b0, 4'd3,  8'hFF, 8'h04, 8'h00},
        {1'b0, 4'd3,  8'h02, 8'h11, 8'h00},
        {1'b1, 4'd3,  8'h02, 8'h00, 8'h11},  // R3 channel 0
        {1'b1, 4'd1,  8'hFF, 8'h00, 8'h04},  // R1 page readback
        {1'b0, 4'd3,  8'hFF, 8'h05, 8'h00},
        {1'b0, 4'd3,  8'h02, 8'h22, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h06, 8'h00},
        {1'b0, 4'd3,  8'h02, 8'h33, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h07, 8'h00},
        {1'b0, 4'd3,  8'h02, 8'h44, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h04, 8'h00},
        {1'b1, 4'd3,  8'h02, 8'h00, 8'h11},  // R3 channel 0 kept
        {1'b0, 4'd3,  8'hFF, 8'h05, 8'h00},
        {1'b1, 4'd3,  8'h02, 8'h00, 8'h22},  // R3 channel 1
        {1'b0, 4'd1,  8'hFF, 8'h00, 8'h00},  // R1 write page from channel page
        {1'b1, 4'd2,  8'h02, 8'h00, 8'h3C},  // R2 common untouched
        {1'b0, 4'd4,  8'hFF, 8'h0C, 8'h00},
        {1'b0, 4'd4,  8'h03, 8'h99, 8'h00},
        {1'b0, 4'd4,  8'hFF, 8'h0E, 8'h00},
        {1'b1, 4'd4,  8'h03, 8'h00, 8'h99},  // R4 broadcast seen on ch2
        {1'b1, 4'd4,  8'h02, 8'h00, 8'h33},  // R4 read from selected ch2
        {1'b0, 4'd4,  8'hFF, 8'h07, 8'h00},
        {1'b1, 4'd4,  8'h03, 8'h00, 8'h99},  // R4 broadcast seen on ch3
        {1'b0, 4'd11, 8'h09, 8'h77, 8'h00},
        {1'b1, 4'd11, 8'h09, 8'h00, 8'h00},  // R11 channel out of range
        {1'b0, 4'd11, 8'hFF, 8'h00, 8'h00},
        {1'b0, 4'd11, 8'h0A, 8'h5A, 8'h00},
        {1'b1, 4'd11, 8'h0A, 8'h00, 8'h00},  // R11 common unimplemented
        {1'b1, 4'd2,  8'h07, 8'h00, 8'h05}   // R2 / R10 scratch 7 default
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset defaults
        rd(8'hFF, v); check(10, v, 8'h00);
        rd(8'h04, v); check(10, v, 8'h01);
        rd(8'h07, v); check(10, v, 8'h05);
        rd(8'h02, v); check(10, v, 8'h00);
        check(10, {7'b0, master_rst_pulse}, 8'h00);
        // R8 bus address
        check(8, {1'b0, bus_addr}, 8'h22);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                rd(VEC[i][23:16], v);
                check(int'(VEC[i][27:24]), v, VEC[i][7:0]);
            end else begin
                wr(VEC[i][23:16], VEC[i][15:8]);
            end
        end

        // R6 soft reset from a nonzero page byte; channels keep contents
        wr(8'h07, 8'hF0);
        wr(8'hFF, 8'h30);
        wr(8'h04, 8'h40);
        rd(8'hFF, v); check(6, v, 8'h00);
        rd(8'h04, v); check(6, v, 8'h01);
        rd(8'h07, v); check(6, v, 8'h05);
        rd(8'h02, v); check(6, v, 8'h00);
        ch_irq = 4'b1000;
        rd(8'h05, v); check(9, v, 8'h11);  // R9 channel 3 at bit 0
        wr(8'hFF, 8'h06);
        rd(8'h02, v); check(6, v, 8'h33);
        rd(8'h03, v); check(6, v, 8'h99);

        // R7 master reset pulse lasts one cycle
        wr(8'hFF, 8'h00);
        @(negedge clk);
        addr = 8'h04; wdata = 8'h21; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(7, {7'b0, master_rst_pulse}, 8'h01);
        @(negedge clk);
        check(7, {7'b0, master_rst_pulse}, 8'h00);
        rd(8'h04, v); check(7, v, 8'h01);

        // R12 read during write returns old value, then new
        @(negedge clk);
        addr = 8'h02; wdata = 8'hAB; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(12, rdata, 8'h00);
        repeat (3) @(negedge clk);
        check(12, rdata, 8'h00);  // R12 hold without strobe
        rd(8'h02, v); check(12, v, 8'hAB);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule